// File: doc/BRIEF.md
# Two-Group Interrupt Processor Port

This block is the per-processor end of an interrupt controller that sorts interrupts into two groups. Group 0 is the secure, higher-priority group. Group 1 is the non-secure, lower-priority group. A distributor model supplies the single best pending candidate as an ID, a priority and a group bit. The block decides whether that candidate is forwarded to the processor, and on which line: IRQ or FIQ.

Software reaches the block through a one-access-per-cycle register port. Every access carries a secure attribute. There are four registers: a banked control register, an acknowledge register, an end-of-interrupt register and a highest-pending register. The group of the interrupt and the secure bit of the access together decide whether an acknowledge or a completion is honoured. A successful acknowledge raises `ack_take` for the distributor.

The block is a two-state machine:
- ST_IDLE: no interrupt is active.
- ACK_GRANT: a permitted acknowledge moves the block from ST_IDLE to ST_ACTIVE and latches the ID and group.
- ST_ACTIVE: one interrupt is active.
- EOI_MATCH: a permitted completion of the latched ID moves the block from ST_ACTIVE back to ST_IDLE.

In all other cases the state holds.

Top module: `grp_cpu_iface`

## Requirements
- R1: After reset, `irq` and `fiq` are low, `rd_valid` is low, and a secure read of the control register returns 0.
- R2: A pending group 1 candidate with the group 1 enable set asserts `irq` and never `fiq`.
- R3: A pending group 0 candidate with the group 0 enable set asserts `fiq` when the FIQ-select bit is set, and `irq` otherwise. `irq` and `fiq` are never high together.
- R4: Reading the acknowledge register (select 1) for a group 0 candidate returns its ID, raises `ack_take` and enters ST_ACTIVE, but only for a secure access. A non-secure access gets 1023 and leaves the state unchanged.
- R5: A non-secure acknowledge of a group 1 candidate succeeds. A secure acknowledge of a group 1 candidate succeeds only when the ack-control bit is set, and otherwise returns 1023.
- R6: A write to the end-of-interrupt register (select 2) completes the active interrupt only when bits [31:0] equal its ID and the access is secure or the active interrupt is group 1. Any other completion write is ignored and the block stays in ST_ACTIVE.
- R7: The control register (select 0) holds bit 0 group 0 enable, bit 1 group 1 enable, bit 2 ack-control and bit 3 FIQ-select. Secure accesses see all four bits. Non-secure accesses see and write only the group 1 enable, at bit 0.
- R8: A read of the highest-pending register (select 3) returns the candidate ID when an acknowledge by that access would succeed. It returns 1022 when a secure access faces a group 1 candidate with ack-control clear. It returns 1023 otherwise, including during ST_ACTIVE.
- R9: In ST_ACTIVE, both lines are low and acknowledges return 1023. After a successful completion, signalling resumes from the same clock edge.
- R10: A candidate whose group enable is clear is neither signalled nor acknowledged.
- R11: A candidate with priority 0xFF is neither signalled nor acknowledged.
- R12: Read data appears on `rd_data` with `rd_valid` high one cycle after the read access. End-of-interrupt reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hp_valid | input | 1 | Distributor has a pending candidate |
| hp_id | input | 10 | Candidate interrupt ID |
| hp_prio | input | 8 | Candidate priority, lower is more urgent |
| hp_grp | input | 1 | Candidate group (0 or 1) |
| acc_valid | input | 1 | Register access this cycle |
| acc_write | input | 1 | 1 write, 0 read |
| acc_secure | input | 1 | Secure attribute of the access |
| acc_reg | input | 2 | Register select: 0 control, 1 acknowledge, 2 end-of-interrupt, 3 highest-pending |
| acc_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 32 | Read response data |
| ack_take | output | 1 | Combinational pulse during a successful acknowledge |
| irq | output | 1 | Normal interrupt line |
| fiq | output | 1 | Fast interrupt line |

## Verification
Completion and re-signalling can land on the same clock edge. The bench provokes this by completing an interrupt while the distributor still presents a pending candidate. It then judges that the interrupt line is already high at the first sample after the completion access. Acknowledge and routing also meet in one cycle: the acknowledge read is checked for its returned ID, for the `ack_take` pulse in that cycle, and for the line dropping right after the same edge. Each of these checks is repeated for group 0 and for group 1, under secure and under non-secure accesses.

// File: rtl/grp_cpu_pkg.sv
package grp_cpu_pkg;
    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_ACK   = 2'd1,
        REG_EOI   = 2'd2,
        REG_HPEND = 2'd3
    } reg_sel_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } if_state_e;

    typedef struct packed {
        logic fiq_sel;
        logic ack_ctl;
        logic g1_en;
        logic g0_en;
    } ctrl_t;

    localparam int ID_NONE    = 1023;
    localparam int ID_GRP_ALT = 1022;
endpackage

// File: rtl/grp_ctrl_bank.sv
module grp_ctrl_bank
    import grp_cpu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              sec,
    input  logic [3:0]        wr_bits,
    output ctrl_t             ctrl_q,
    output ctrl_t             ctrl_d,
    output logic [DATA_W-1:0] view
);
    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en) begin
            if (sec) ctrl_d = ctrl_t'(wr_bits);
            else     ctrl_d.g1_en = wr_bits[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    always_comb begin
        view = '0;
        if (sec) view[3:0] = ctrl_q;
        else     view[0]   = ctrl_q.g1_en;
    end
endmodule

// File: rtl/grp_route.sv
module grp_route
    import grp_cpu_pkg::*;
#(
    parameter int PRIO_W = 8
) (
    input  if_state_e         state,
    input  ctrl_t             ctrl,
    input  logic              hp_valid,
    input  logic [PRIO_W-1:0] hp_prio,
    input  logic              hp_grp,
    output logic              elig,
    output logic              to_irq,
    output logic              to_fiq
);
    localparam logic [PRIO_W-1:0] PRIO_IDLE = '1;

    always_comb begin
        elig   = hp_valid && (hp_prio != PRIO_IDLE) && (state == ST_IDLE)
                 && (hp_grp ? ctrl.g1_en : ctrl.g0_en);
        to_fiq = elig && !hp_grp && ctrl.fiq_sel;
        to_irq = elig && !to_fiq;
    end
endmodule

// File: rtl/grp_ack_fsm.sv
module grp_ack_fsm
    import grp_cpu_pkg::*;
#(
    parameter int ID_W   = 10,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              acc_secure,
    input  reg_sel_e          acc_reg,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic [ID_W-1:0]   hp_id,
    input  logic              hp_grp,
    input  logic              elig,
    input  logic              ack_ctl,
    output if_state_e         state_q,
    output if_state_e         state_d,
    output logic              ack_ok,
    output logic [ID_W-1:0]   ack_value,
    output logic [ID_W-1:0]   hpend_value
);
    localparam logic [ID_W-1:0] SPUR = ID_W'(ID_NONE);
    localparam logic [ID_W-1:0] ALT  = ID_W'(ID_GRP_ALT);

    logic [ID_W-1:0] act_id;
    logic            act_grp;
    logic            grp_ok, ack_rd, eoi_wr, eoi_ok;

    always_comb begin
        grp_ok = acc_secure ? (hp_grp ? ack_ctl : 1'b1) : hp_grp;
        ack_rd = acc_valid && !acc_write && (acc_reg == REG_ACK);
        eoi_wr = acc_valid && acc_write && (acc_reg == REG_EOI);
        ack_ok = ack_rd && elig && grp_ok;
        eoi_ok = eoi_wr && (state_q == ST_ACTIVE)
                 && (acc_wdata == DATA_W'(act_id)) && (act_grp || acc_secure);
        ack_value = (elig && grp_ok) ? hp_id : SPUR;
        if (!elig)                          hpend_value = SPUR;
        else if (grp_ok)                    hpend_value = hp_id;
        else if (acc_secure && hp_grp)      hpend_value = ALT;
        else                                hpend_value = SPUR;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (ack_ok) state_d = ST_ACTIVE;
            ST_ACTIVE: if (eoi_ok) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            act_id  <= '0;
            act_grp <= 1'b0;
        end else begin
            state_q <= state_d;
            if (ack_ok) begin
                act_id  <= hp_id;
                act_grp <= hp_grp;
            end
        end
    end

    assert_ack_enters_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ack_ok |=> (state_q == ST_ACTIVE));

    assert_ns_g0_eoi_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr && !acc_secure && (state_q == ST_ACTIVE) && !act_grp) |=> (state_q == ST_ACTIVE));
endmodule

// File: rtl/grp_cpu_iface.sv
module grp_cpu_iface
    import grp_cpu_pkg::*;
#(
    parameter int ID_W   = 10,
    parameter int PRIO_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hp_valid,
    input  logic [ID_W-1:0]   hp_id,
    input  logic [PRIO_W-1:0] hp_prio,
    input  logic              hp_grp,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              acc_secure,
    input  logic [1:0]        acc_reg,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              ack_take,
    output logic              irq,
    output logic              fiq
);
    reg_sel_e          sel;
    ctrl_t             ctrl_q, ctrl_d;
    logic [DATA_W-1:0] ctrl_view;
    if_state_e         state_q, state_d;
    logic              elig_now, irq_now, fiq_now;
    logic              elig_nx, irq_nx, fiq_nx;
    logic [ID_W-1:0]   ack_value, hpend_value;
    logic [DATA_W-1:0] rd_mux;

    assign sel = reg_sel_e'(acc_reg);

    grp_ctrl_bank #(.DATA_W(DATA_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(acc_valid && acc_write && (sel == REG_CTRL)),
        .sec(acc_secure), .wr_bits(acc_wdata[3:0]),
        .ctrl_q(ctrl_q), .ctrl_d(ctrl_d), .view(ctrl_view)
    );

    grp_route #(.PRIO_W(PRIO_W)) u_route_now (
        .state(state_q), .ctrl(ctrl_q), .hp_valid(hp_valid), .hp_prio(hp_prio),
        .hp_grp(hp_grp), .elig(elig_now), .to_irq(irq_now), .to_fiq(fiq_now)
    );

    grp_route #(.PRIO_W(PRIO_W)) u_route_nx (
        .state(state_d), .ctrl(ctrl_d), .hp_valid(hp_valid), .hp_prio(hp_prio),
        .hp_grp(hp_grp), .elig(elig_nx), .to_irq(irq_nx), .to_fiq(fiq_nx)
    );

    grp_ack_fsm #(.ID_W(ID_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_secure(acc_secure), .acc_reg(sel), .acc_wdata(acc_wdata),
        .hp_id(hp_id), .hp_grp(hp_grp), .elig(elig_now), .ack_ctl(ctrl_q.ack_ctl),
        .state_q(state_q), .state_d(state_d), .ack_ok(ack_take),
        .ack_value(ack_value), .hpend_value(hpend_value)
    );

    always_comb begin
        unique case (sel)
            REG_CTRL:  rd_mux = ctrl_view;
            REG_ACK:   rd_mux = DATA_W'(ack_value);
            REG_EOI:   rd_mux = '0;
            REG_HPEND: rd_mux = DATA_W'(hpend_value);
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            irq      <= 1'b0;
            fiq      <= 1'b0;
        end else begin
            rd_valid <= acc_valid && !acc_write;
            if (acc_valid && !acc_write) rd_data <= rd_mux;
            irq <= irq_nx;
            fiq <= fiq_nx;
        end
    end

    assert_lines_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq && fiq));

    assert_fiq_needs_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fiq |-> ctrl_q.fiq_sel);

    assert_quiet_when_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE) |-> (!irq && !fiq));

    assert_rd_follows_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> $past(acc_valid && !acc_write));

    assert_take_needs_ack_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ack_take |-> (acc_valid && !acc_write && (sel == REG_ACK)));

    logic unused_now;
    assign unused_now = irq_now ^ fiq_now ^ elig_nx;
endmodule

// File: tb/grp_cpu_iface_tb.sv
`timescale 1ns/1ps
module grp_cpu_iface_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hp_valid = 1'b0;
    logic [9:0]  hp_id = '0;
    logic [7:0]  hp_prio = '0;
    logic        hp_grp = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0, acc_secure = 1'b0;
    logic [1:0]  acc_reg = '0;
    logic [31:0] acc_wdata = '0;
    logic        rd_valid, ack_take, irq, fiq;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        last_take;

    always #2.5 clk = ~clk;

    grp_cpu_iface u_dut (
        .clk(clk), .rst_n(rst_n), .hp_valid(hp_valid), .hp_id(hp_id),
        .hp_prio(hp_prio), .hp_grp(hp_grp), .acc_valid(acc_valid),
        .acc_write(acc_write), .acc_secure(acc_secure), .acc_reg(acc_reg),
        .acc_wdata(acc_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .ack_take(ack_take), .irq(irq), .fiq(fiq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: pops scoreboard on each read response
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) chk("R12 unexpected response", 1, 0);
            else chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
        end
    end

    task automatic acc(input logic wr, input logic sec, input logic [1:0] r, input logic [31:0] d);
        acc_valid = 1'b1; acc_write = wr; acc_secure = sec; acc_reg = r; acc_wdata = d;
        #1 last_take = ack_take;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic rd(input logic sec, input logic [1:0] r, input logic [31:0] exp, input string tag);
        exp_q.push_back(exp); tag_q.push_back(tag);
        acc(1'b0, sec, r, 32'd0);
    endtask

    task automatic wr(input logic sec, input logic [1:0] r, input logic [31:0] d);
        acc(1'b1, sec, r, d);
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic lines(input logic ei, input logic ef, input string tag);
        chk({tag, " irq"}, irq, ei);
        chk({tag, " fiq"}, fiq, ef);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        lines(0, 0, "R1 reset");
        chk("R1 rd_valid", rd_valid, 0);
        rd(1, 0, 0, "R1 ctrl reset");

        // group 1 candidate, enables clear
        hp_valid = 1; hp_id = 40; hp_prio = 8'h10; hp_grp = 1;
        idle(); lines(0, 0, "R10 disabled g1");
        rd(1, 1, 1023, "R10 ack disabled");

        wr(0, 0, 32'h1);                 // non-secure sets g1 enable
        rd(0, 0, 1, "R7 ns ctrl view");
        rd(1, 0, 2, "R7 sec ctrl view");
        lines(1, 0, "R2 g1 on irq");
        rd(1, 3, 1022, "R8 sec hpend g1 ackctl=0");
        rd(0, 3, 40, "R8 ns hpend g1");
        rd(1, 1, 1023, "R5 sec ack g1 ackctl=0");
        chk("R5 no take", last_take, 0);
        rd(0, 1, 40, "R5 ns ack g1");
        chk("R5 take", last_take, 1);
        lines(0, 0, "R9 active quiet");
        rd(0, 1, 1023, "R9 ack while active");
        rd(0, 3, 1023, "R8 hpend while active");
        wr(0, 2, 41);                    // wrong id
        lines(0, 0, "R6 wrong id ignored");
        rd(0, 1, 1023, "R6 still active");
        wr(0, 2, 40);                    // completes; candidate still pending
        lines(1, 0, "R9 resume same edge");

        wr(1, 0, 32'h6);                 // g1 enable + ack-control
        rd(1, 1, 40, "R5 sec ack g1 ackctl=1");
        chk("R5 take sec", last_take, 1);
        wr(1, 2, 40);
        lines(1, 0, "R6 secure completes g1");

        // group 0 candidate
        hp_id = 7; hp_prio = 8'h20; hp_grp = 0;
        idle(); lines(0, 0, "R10 disabled g0");
        wr(1, 0, 32'h7);
        lines(1, 0, "R3 g0 on irq");
        wr(1, 0, 32'hF);
        lines(0, 1, "R3 g0 on fiq");
        wr(0, 0, 32'h0);                 // ns clears only g1 enable
        rd(1, 0, 13, "R7 ns write bank");
        lines(0, 1, "R7 g0 unaffected");
        rd(0, 3, 1023, "R8 ns hpend g0");
        rd(1, 3, 7, "R8 sec hpend g0");
        rd(0, 1, 1023, "R4 ns ack g0");
        chk("R4 no take", last_take, 0);
        lines(0, 1, "R4 still pending");
        rd(1, 1, 7, "R4 sec ack g0");
        chk("R4 take", last_take, 1);
        lines(0, 0, "R4 active");
        wr(0, 2, 7);
        idle(); lines(0, 0, "R6 ns eoi g0 ignored");
        rd(1, 2, 0, "R12 eoi read zero");
        wr(1, 2, 7);
        lines(0, 1, "R6 sec eoi g0");

        hp_prio = 8'hFF;
        idle(); lines(0, 0, "R11 idle priority");
        rd(1, 1, 1023, "R11 ack idle priority");

        repeat (3) idle();
        chk("R12 scoreboard drained", exp_q.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule